// File: doc/BRIEF.md
# One-wire ROM command layer with resume selection

This block sits between the bit-level link layer of a single-wire slave device and its memory-function layer. After every bus reset it takes the first received byte as a ROM command and decides whether this device is the one the master wants to talk to. When it is, the block raises a grant that hands the following traffic to the memory functions. The grant stays up until the next bus reset.

The commands are Read ROM (33h), Match ROM (55h), Search ROM (F0h), Skip ROM (CCh) and Resume (A5h). Match ROM compares the received ID bytes with the device ID. Search ROM counts the per-bit compare results that the link layer reports during the search walk. A resume flag is set whenever one of these two addressing commands completes. While the flag is set, a single Resume byte selects the device again without sending the ID. Any command that addresses another device, or all devices together, clears the flag. This keeps two devices from answering the same Resume.

Top module: `owr_rom_layer`

## Requirements
- R1: After rst_ni is released, mem_grant_o and search_active_o are low and the resume flag is clear. A Resume (A5h) sent before any successful addressing therefore leaves mem_grant_o low.
- R2: A Match ROM command (55h) followed by ID_W/8 bytes raises mem_grant_o and sets the resume flag when every byte equals the device ID. The bytes are taken least significant byte first, so byte k is compared with dev_id_i[8k+7:8k].
- R3: If any Match ROM ID byte differs from the device ID, mem_grant_o stays low and the resume flag is cleared. All further bytes are ignored until the next bus reset.
- R4: After Search ROM (F0h), search_active_o is high while the block collects compare results. ID_W results with id_bit_ok_i high raise mem_grant_o and set the flag. Any result with id_bit_ok_i low clears the flag, drops search_active_o and ignores traffic until the next bus reset.
- R5: With the flag set, Resume (A5h) raises mem_grant_o. This can be repeated after any number of bus resets.
- R6: With the flag clear, Resume leaves mem_grant_o low, and later bytes are ignored until the next bus reset.
- R7: Skip ROM (CCh) and Read ROM (33h) both raise mem_grant_o and clear the resume flag.
- R8: A command byte other than the five codes leaves mem_grant_o low and does not change the flag. Bytes after it are ignored until the next bus reset.
- R9: bus_reset_i drops mem_grant_o and search_active_o on the next cycle and makes the next byte a ROM command. It takes priority over a byte or bit strobe in the same cycle and does not change the flag.
- R10: While mem_grant_o is high, received bytes do not change the grant or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_reset_i | input | 1 | One-cycle strobe: reset pulse seen on the bus |
| byte_valid_i | input | 1 | One-cycle strobe: a byte has been received |
| byte_data_i | input | 8 | Received byte |
| id_bit_valid_i | input | 1 | One-cycle strobe: one search bit has been resolved |
| id_bit_ok_i | input | 1 | The master's chosen search bit equals this device's ID bit |
| dev_id_i | input | ID_W | Device ID |
| search_active_o | output | 1 | Search walk in progress; the link layer runs search bit exchanges |
| mem_grant_o | output | 1 | Control has passed to the memory-function layer |

## Verification
The bench builds the block with ID_W = 16. This gives two ID bytes and sixteen search bits, so a mismatch in the first or the last byte and a failure on the final search bit can each be reached in a few cycles. A reference model of the resume flag follows a random mix of addressing, Resume, Skip, Read and unknown commands across several hundred bus resets. This exercises every transition of the flag, including repeated Resume selections and the clearing of the flag when another device is addressed.

// File: rtl/owr_pkg.sv
package owr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_MATCH, ST_SEARCH, ST_MEM
  } rom_state_e;

  typedef enum logic [2:0] {
    CMD_READ, CMD_MATCH, CMD_SEARCH, CMD_SKIP, CMD_RESUME, CMD_BAD
  } rom_cmd_e;

  localparam logic [7:0] CODE_READ   = 8'h33;
  localparam logic [7:0] CODE_MATCH  = 8'h55;
  localparam logic [7:0] CODE_SEARCH = 8'hF0;
  localparam logic [7:0] CODE_SKIP   = 8'hCC;
  localparam logic [7:0] CODE_RESUME = 8'hA5;
endpackage

// File: rtl/owr_rom_cmd_dec.sv
module owr_rom_cmd_dec
  import owr_pkg::*;
(
  input  logic [7:0] code_i,
  output rom_cmd_e   cmd_o
);
  always_comb begin
    unique case (code_i)
      CODE_READ:   cmd_o = CMD_READ;
      CODE_MATCH:  cmd_o = CMD_MATCH;
      CODE_SEARCH: cmd_o = CMD_SEARCH;
      CODE_SKIP:   cmd_o = CMD_SKIP;
      CODE_RESUME: cmd_o = CMD_RESUME;
      default:     cmd_o = CMD_BAD;
    endcase
  end
endmodule

// File: rtl/owr_rom_step_cnt.sv
module owr_rom_step_cnt #(
  parameter int STEPS = 8,
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          step_i,
  output logic [CW-1:0] idx_o,
  output logic          last_o
);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (step_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign idx_o  = cnt_q;
  assign last_o = (cnt_q == LAST);

  a_r2_cnt_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
endmodule

// File: rtl/owr_rom_layer.sv
module owr_rom_layer
  import owr_pkg::*;
#(
  parameter int ID_W = 64,
  localparam int ID_BYTES = ID_W / 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_reset_i,
  input  logic            byte_valid_i,
  input  logic [7:0]      byte_data_i,
  input  logic            id_bit_valid_i,
  input  logic            id_bit_ok_i,
  input  logic [ID_W-1:0] dev_id_i,
  output logic            search_active_o,
  output logic            mem_grant_o
);
  localparam int BCW = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;
  localparam int SCW = $clog2(ID_W);

  rom_state_e state_q, state_d;
  logic       flag_q, flag_d;
  rom_cmd_e   cmd;

  logic [BCW-1:0] byte_idx;
  logic [SCW-1:0] bit_idx;
  logic           byte_last, bit_last, byte_eq;

  owr_rom_cmd_dec i_dec (.code_i(byte_data_i), .cmd_o(cmd));

  owr_rom_step_cnt #(.STEPS(ID_BYTES)) i_byte_cnt (
    .clk_i, .rst_ni,
    .en_i(state_q == ST_MATCH), .step_i(byte_valid_i),
    .idx_o(byte_idx), .last_o(byte_last)
  );

  owr_rom_step_cnt #(.STEPS(ID_W)) i_bit_cnt (
    .clk_i, .rst_ni,
    .en_i(state_q == ST_SEARCH), .step_i(id_bit_valid_i),
    .idx_o(bit_idx), .last_o(bit_last)
  );

  // ID bytes arrive least significant first
  assign byte_eq = (byte_data_i == dev_id_i[byte_idx*8 +: 8]);

  always_comb begin
    state_d = state_q;
    flag_d  = flag_q;
    if (bus_reset_i) begin
      state_d = ST_CMD;
    end else begin
      unique case (state_q)
        ST_CMD: if (byte_valid_i) begin
          unique case (cmd)
            CMD_READ, CMD_SKIP: begin state_d = ST_MEM; flag_d = 1'b0; end
            CMD_MATCH:  state_d = ST_MATCH;
            CMD_SEARCH: state_d = ST_SEARCH;
            CMD_RESUME: state_d = flag_q ? ST_MEM : ST_IDLE;
            default:    state_d = ST_IDLE;
          endcase
        end
        ST_MATCH: if (byte_valid_i) begin
          if (!byte_eq)       begin state_d = ST_IDLE; flag_d = 1'b0; end
          else if (byte_last) begin state_d = ST_MEM;  flag_d = 1'b1; end
        end
        ST_SEARCH: if (id_bit_valid_i) begin
          if (!id_bit_ok_i)  begin state_d = ST_IDLE; flag_d = 1'b0; end
          else if (bit_last) begin state_d = ST_MEM;  flag_d = 1'b1; end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      flag_q  <= flag_d;
    end
  end

  assign mem_grant_o     = (state_q == ST_MEM);
  assign search_active_o = (state_q == ST_SEARCH);

  a_r9_reset_drops_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> !mem_grant_o && !search_active_o && $stable(flag_q));
  a_r5_resume_grants: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_CMD && byte_valid_i && !bus_reset_i && byte_data_i == CODE_RESUME && flag_q
    |=> mem_grant_o);
  a_r6_resume_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_CMD && byte_valid_i && !bus_reset_i && byte_data_i == CODE_RESUME && !flag_q
    |=> !mem_grant_o);
  a_r7_skip_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_CMD && byte_valid_i && !bus_reset_i && byte_data_i == CODE_SKIP
    |=> mem_grant_o && !flag_q);
  a_r3_mismatch_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_MATCH && byte_valid_i && !bus_reset_i && !byte_eq
    |=> !flag_q && !mem_grant_o);
  a_r4_search_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    search_active_o && id_bit_valid_i && !id_bit_ok_i && !bus_reset_i
    |=> !search_active_o && !flag_q && !mem_grant_o);
  a_r10_grant_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_grant_o && !bus_reset_i |=> mem_grant_o && $stable(flag_q));
  a_r1_no_dual_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_grant_o && search_active_o));
endmodule

// File: tb/test_owr_rom_layer.sv
module test_owr_rom_layer;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 16;
  localparam int NB = ID_W / 8;

  logic clk = 0, rst_ni = 0;
  logic bus_reset = 0, byte_valid = 0, bit_valid = 0, bit_ok = 0;
  logic [7:0] byte_data = '0;
  logic [ID_W-1:0] dev_id = 16'hB39E;
  logic search_active, grant;

  int checks = 0, errors = 0;
  logic exp_flag = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  owr_rom_layer #(.ID_W(ID_W)) i_owr_rom_layer (
    .clk_i(clk), .rst_ni, .bus_reset_i(bus_reset),
    .byte_valid_i(byte_valid), .byte_data_i(byte_data),
    .id_bit_valid_i(bit_valid), .id_bit_ok_i(bit_ok),
    .dev_id_i(dev_id), .search_active_o(search_active), .mem_grant_o(grant)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_rst();
    @(negedge clk) bus_reset = 1;
    @(negedge clk) bus_reset = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk) begin byte_valid = 1; byte_data = b; end
    @(negedge clk) byte_valid = 0;
  endtask

  task automatic send_bit(input logic ok);
    @(negedge clk) begin bit_valid = 1; bit_ok = ok; end
    @(negedge clk) bit_valid = 0;
  endtask

  // bad_idx < 0 : all bytes correct
  task automatic do_match(input int bad_idx);
    send_byte(8'h55);
    for (int k = 0; k < NB; k++)
      send_byte(k == bad_idx ? dev_id[k*8 +: 8] ^ 8'h01 : dev_id[k*8 +: 8]);
  endtask

  task automatic do_search(input int fail_idx);
    send_byte(8'hF0);
    for (int k = 0; k < ID_W; k++) begin
      send_bit(k != fail_idx);
      if (k == fail_idx) break;
    end
  endtask

  function automatic logic [7:0] unknown_code(input logic [7:0] r);
    logic [7:0] c = r;
    if (c == 8'h33 || c == 8'h55 || c == 8'hF0 || c == 8'hCC || c == 8'hA5) c = 8'h00;
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic eg;
    void'($urandom(32'd2025));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 grant after reset", grant, 0);
    chk("R1 search idle after reset", search_active, 0);

    bus_rst(); send_byte(8'hA5);
    chk("R1 resume with clear flag", grant, 0);

    bus_rst(); do_match(-1);
    chk("R2 match grants", grant, 1);
    send_byte(8'h55); send_byte(8'hF0);
    chk("R10 bytes while granted", grant, 1);
    exp_flag = 1;

    for (int n = 0; n < 3; n++) begin
      bus_rst();
      chk("R9 bus reset drops grant", grant, 0);
      send_byte(8'hA5);
      chk("R5 repeated resume", grant, 1);
    end

    bus_rst(); send_byte(8'hCC);
    chk("R7 skip grants", grant, 1);
    bus_rst(); send_byte(8'hA5);
    chk("R7 skip cleared flag", grant, 0);
    send_byte(8'hCC);
    chk("R6 ignored after blocked resume", grant, 0);

    bus_rst(); do_match(-1); bus_rst(); send_byte(8'h33);
    chk("R7 read grants", grant, 1);
    bus_rst(); send_byte(8'hA5);
    chk("R7 read cleared flag", grant, 0);

    bus_rst(); send_byte(8'hF0);
    chk("R4 search active", search_active, 1);
    for (int k = 0; k < ID_W; k++) send_bit(1);
    chk("R4 search grants", grant, 1);
    chk("R4 search ends", search_active, 0);
    bus_rst(); send_byte(8'hA5);
    chk("R4 search set flag", grant, 1);

    bus_rst(); do_match(NB - 1);
    chk("R3 last byte mismatch", grant, 0);
    send_byte(8'hCC);
    chk("R3 ignored after mismatch", grant, 0);
    bus_rst(); send_byte(8'hA5);
    chk("R3 mismatch cleared flag", grant, 0);

    bus_rst(); do_match(-1);
    bus_rst(); send_byte(8'h12);
    chk("R8 unknown no grant", grant, 0);
    send_byte(8'hA5);
    chk("R8 ignored after unknown", grant, 0);
    bus_rst(); send_byte(8'hA5);
    chk("R8 flag kept", grant, 1);

    bus_rst(); do_search(ID_W - 1);
    chk("R4 last bit fail", grant, 0);
    chk("R4 drops search", search_active, 0);
    bus_rst(); send_byte(8'hA5);
    chk("R4 fail cleared flag", grant, 0);

    // R9 priority: reset and byte in same cycle
    bus_rst(); do_match(-1);
    @(negedge clk) begin bus_reset = 1; byte_valid = 1; byte_data = 8'hCC; end
    @(negedge clk) begin bus_reset = 0; byte_valid = 0; end
    chk("R9 reset wins over byte", grant, 0);
    send_byte(8'hA5);
    chk("R9 flag kept across reset", grant, 1);
    exp_flag = 1;

    for (int it = 0; it < 300; it++) begin
      int op = $urandom_range(0, 7);
      bus_rst();
      case (op)
        0: begin do_match(-1); eg = 1; exp_flag = 1; end
        1: begin do_match($urandom_range(0, NB-1)); eg = 0; exp_flag = 0; end
        2: begin do_search(-1); eg = 1; exp_flag = 1; end
        3: begin do_search($urandom_range(0, ID_W-1)); eg = 0; exp_flag = 0; end
        4: begin send_byte(8'hA5); eg = exp_flag; end
        5: begin send_byte(8'hCC); eg = 1; exp_flag = 0; end
        6: begin send_byte(8'h33); eg = 1; exp_flag = 0; end
        default: begin send_byte(unknown_code(8'($urandom))); eg = 0; end
      endcase
      chk($sformatf("R2/R3/R4/R5/R6/R7/R8 random op %0d", op), grant, eg);
      send_byte(8'($urandom));
      chk("R10 trailing byte", grant, eg);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule